// File: doc/BRIEF.md
# Pass-Through Data Channel with Posting, Prefetch and Retry

This block sits between a fast 32-bit host target port and a slow local bus. A host write either goes into a write-posting queue, which the local side drains in order, or, when posting is off, runs in real time through a single held request slot. A host read either comes from a read-prefetch queue that the block fills ahead of the host, or, when prefetch is off, runs in real time through the same held slot. Each queue holds 32 bytes (eight 32-bit words) and has its own enable input.

The host side never waits. Every host beat gets a one-cycle answer in the next cycle: accept (`h_ack`, with read data for reads) or retry (`h_retry`). A retried real-time access stays latched and is started on the local bus. When the host repeats the same access after the local side has finished it, the access completes. Every local request carries its direction, byte lanes, region number and burst flag. The local side finishes a request by pulsing `loc_ack`.

Top module: `ptc_top`

## Requirements
- R1: After reset, `h_ack`, `h_retry` and `loc_req` are low. Each host beat (`h_req` high at a clock edge) gets exactly one of `h_ack` or `h_retry`, high for the single following cycle. No answer appears without a beat.
- R2: With posting on (`wf_en`=1), a host write is acked in the next cycle whenever the posting queue is not full. Back-to-back beats are acked every cycle whatever the local side does.
- R3: With posting on, a host write that finds eight words already queued is answered with retry, and nothing is queued. Once the local side drains, a repeat of that write is accepted.
- R4: Posted writes reach the local bus strictly in host order. Address, data, byte enables (`h_be` bit n = byte lane n), region and burst flag are unchanged.
- R5: With posting off, a host write is retried and latched. The latched write is then performed on the local bus. The host repeating the same address and region gets an ack once the local write has completed.
- R6: With prefetch off, a host read is retried and latched. The local read is performed, and a repeat of the same read is acked with the data the local side returned.
- R7: With prefetch on, a read that starts a new stream is retried. The block then fetches consecutive words from that address (step 4 bytes) until the prefetch queue holds eight words. Subsequent reads at consecutive addresses are acked back-to-back with the fetched data.
- R8: A read whose region differs from the stream's, or whose address is not the next consecutive one, flushes the prefetch queue, is retried and restarts the stream at its own address. The data later returned for it belongs to the new address and region.
- R9: Any accepted host write flushes the prefetch queue, so the next read, even at the next consecutive address, is retried.
- R10: A prefetch request on the local bus is a read (`loc_we`=0) with all byte lanes on, `loc_burst`=1 and the stream's region. Any local request holds its fields stable until `loc_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wf_en | input | 1 | Enable write posting |
| rf_en | input | 1 | Enable read prefetch |
| h_req | input | 1 | Host beat valid |
| h_we | input | 1 | Host beat is a write |
| h_addr | input | 32 | Host byte address |
| h_be | input | 4 | Host byte lanes |
| h_region | input | 2 | Target region number |
| h_burst | input | 1 | Beat belongs to a burst |
| h_wdata | input | 32 | Host write data |
| h_ack | output | 1 | Beat accepted (one cycle after) |
| h_retry | output | 1 | Beat must be retried |
| h_rdata | output | 32 | Read data, valid with `h_ack` |
| loc_req | output | 1 | Local request pending |
| loc_we | output | 1 | Local request direction |
| loc_addr | output | 32 | Local byte address |
| loc_be | output | 4 | Local byte lanes |
| loc_region | output | 2 | Local region number |
| loc_burst | output | 1 | Local burst flag |
| loc_wdata | output | 32 | Local write data |
| loc_ack | input | 1 | Local side completes the request |
| loc_rdata | input | 32 | Local read data, valid with `loc_ack` |

## Verification
The prefetch queue can be popped by a host read and pushed by a completing local fetch in the same cycle. The posting queue likewise takes a host push while the local side drains its head. The same-cycle read case is provoked by a local responder with zero added latency during an eight-beat back-to-back read burst, so refills land between host pops. It is judged by every beat being acked with the data derived from its own address and region, in order, and by the stream continuing correctly after the burst.

// File: rtl/ptc_pkg.sv
package ptc_pkg;
  // Source of the request currently owning the local bus
  typedef enum logic [1:0] {SRC_NONE, SRC_WR, SRC_RT, SRC_PF} src_e;
  // Real-time slot life cycle
  typedef enum logic [1:0] {RT_IDLE, RT_PEND, RT_BUSY, RT_DONE} rt_e;
endpackage

// File: rtl/ptc_fifo.sv
// Synchronous queue with flush; DEPTH must be a power of two, at least 2.
module ptc_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     flush,
  input  logic                     push,
  input  logic [W-1:0]             din,
  input  logic                     pop,
  output logic [W-1:0]             dout,
  output logic [$clog2(DEPTH):0]   count,
  output logic                     full,
  output logic                     empty
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = PW + 1;
  localparam logic [CW-1:0] FULLV = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic          do_push, do_pop;

  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign full    = (count == FULLV);
  assign empty   = (count == '0);
  assign dout    = mem[rp];

  // storage without reset so it can map onto RAM resources
  always_ff @(posedge clk) begin
    if (do_push && !flush) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (do_push) wp <= (wp == PW'(DEPTH-1)) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == PW'(DEPTH-1)) ? '0 : rp + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/ptc_lport.sv
// Local-bus request port: picks one source at a time and holds it until ack.
// Order: posted writes, then the real-time slot, then prefetch.
module ptc_lport #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int RW = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wf_valid,
  input  logic [AW-1:0]     wf_addr,
  input  logic [DW-1:0]     wf_data,
  input  logic [DW/8-1:0]   wf_be,
  input  logic [RW-1:0]     wf_region,
  input  logic              wf_burst,
  input  logic              rt_pend,
  input  logic              rt_we,
  input  logic [AW-1:0]     rt_addr,
  input  logic [DW-1:0]     rt_data,
  input  logic [DW/8-1:0]   rt_be,
  input  logic [RW-1:0]     rt_region,
  input  logic              rt_burst,
  input  logic              pf_want,
  input  logic [AW-1:0]     pf_addr,
  input  logic [RW-1:0]     pf_region,
  input  logic              loc_ack,
  output logic              loc_req,
  output logic              loc_we,
  output logic [AW-1:0]     loc_addr,
  output logic [DW/8-1:0]   loc_be,
  output logic [RW-1:0]     loc_region,
  output logic              loc_burst,
  output logic [DW-1:0]     loc_wdata,
  output ptc_pkg::src_e     issue_src,
  output ptc_pkg::src_e     cur_src,
  output logic              done
);
  import ptc_pkg::*;

  always_comb begin
    issue_src = SRC_NONE;
    if (!loc_req) begin
      if (wf_valid)     issue_src = SRC_WR;
      else if (rt_pend) issue_src = SRC_RT;
      else if (pf_want) issue_src = SRC_PF;
    end
  end

  assign done = loc_req && loc_ack;

  always_ff @(posedge clk) begin
    if (rst) begin
      loc_req    <= 1'b0;
      loc_we     <= 1'b0;
      loc_addr   <= '0;
      loc_be     <= '0;
      loc_region <= '0;
      loc_burst  <= 1'b0;
      loc_wdata  <= '0;
      cur_src    <= SRC_NONE;
    end else if (issue_src != SRC_NONE) begin
      loc_req <= 1'b1;
      cur_src <= issue_src;
      case (issue_src)
        SRC_WR: begin
          loc_we <= 1'b1; loc_addr <= wf_addr; loc_be <= wf_be;
          loc_region <= wf_region; loc_burst <= wf_burst; loc_wdata <= wf_data;
        end
        SRC_RT: begin
          loc_we <= rt_we; loc_addr <= rt_addr; loc_be <= rt_be;
          loc_region <= rt_region; loc_burst <= rt_burst; loc_wdata <= rt_data;
        end
        default: begin
          loc_we <= 1'b0; loc_addr <= pf_addr; loc_be <= '1;
          loc_region <= pf_region; loc_burst <= 1'b1; loc_wdata <= '0;
        end
      endcase
    end else if (done) begin
      loc_req <= 1'b0;
    end
  end
endmodule

// File: rtl/ptc_top.sv
module ptc_top #(
  parameter int AW         = 32,
  parameter int DW         = 32,
  parameter int RW         = 2,
  parameter int FIFO_BYTES = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wf_en,
  input  logic              rf_en,
  input  logic              h_req,
  input  logic              h_we,
  input  logic [AW-1:0]     h_addr,
  input  logic [DW/8-1:0]   h_be,
  input  logic [RW-1:0]     h_region,
  input  logic              h_burst,
  input  logic [DW-1:0]     h_wdata,
  output logic              h_ack,
  output logic              h_retry,
  output logic [DW-1:0]     h_rdata,
  output logic              loc_req,
  output logic              loc_we,
  output logic [AW-1:0]     loc_addr,
  output logic [DW/8-1:0]   loc_be,
  output logic [RW-1:0]     loc_region,
  output logic              loc_burst,
  output logic [DW-1:0]     loc_wdata,
  input  logic              loc_ack,
  input  logic [DW-1:0]     loc_rdata
);
  import ptc_pkg::*;

  localparam int BEW   = DW / 8;
  localparam int DEPTH = FIFO_BYTES / BEW;
  localparam int CW    = $clog2(DEPTH) + 1;
  localparam int EW    = RW + 1 + BEW + AW + DW;
  localparam logic [CW-1:0] FULLV = CW'(DEPTH);
  localparam logic [AW-1:0] STEP  = AW'(BEW);

  // posting queue
  logic [EW-1:0] wf_din, wf_dout;
  logic [CW-1:0] wf_count;
  logic          wf_full, wf_empty, wf_push, wf_pop;
  // prefetch queue
  logic [DW-1:0] rf_dout;
  logic [CW-1:0] rf_count;
  logic          rf_full, rf_empty, rf_push, rf_pop, rf_flush;
  // prefetch stream state
  logic          pf_valid, pf_discard, pf_want, pf_busy, pf_done;
  logic [RW-1:0] pf_region;
  logic [AW-1:0] pf_haddr, pf_faddr;
  // real-time slot
  rt_e           rt_st;
  logic          rt_we, rt_burst;
  logic [AW-1:0] rt_addr;
  logic [DW-1:0] rt_wdata, rt_rdata;
  logic [BEW-1:0] rt_be;
  logic [RW-1:0] rt_region;
  // host decode
  logic          use_rt, rt_match, rt_latch, pf_hit, pf_miss, ack_n, wr_accept;
  // local port
  src_e          issue_src, cur_src;
  logic          done;

  assign wf_din = {h_region, h_burst, h_be, h_addr, h_wdata};

  ptc_fifo #(.W(EW), .DEPTH(DEPTH)) u_wfifo (
    .clk(clk), .rst(rst), .flush(1'b0), .push(wf_push), .din(wf_din),
    .pop(wf_pop), .dout(wf_dout), .count(wf_count), .full(wf_full), .empty(wf_empty)
  );

  ptc_fifo #(.W(DW), .DEPTH(DEPTH)) u_rfifo (
    .clk(clk), .rst(rst), .flush(rf_flush), .push(rf_push), .din(loc_rdata),
    .pop(rf_pop), .dout(rf_dout), .count(rf_count), .full(rf_full), .empty(rf_empty)
  );

  // host beat decode: every beat ends in ack or retry
  always_comb begin
    use_rt   = h_we ? !wf_en : !rf_en;
    rt_match = (rt_st == RT_DONE) && (rt_we == h_we) &&
               (rt_addr == h_addr) && (rt_region == h_region);
    pf_hit   = pf_valid && (pf_region == h_region) && (pf_haddr == h_addr);
    rt_latch = 1'b0;
    wf_push  = 1'b0;
    rf_pop   = 1'b0;
    pf_miss  = 1'b0;
    ack_n    = 1'b0;
    if (h_req) begin
      if (use_rt) begin
        if (rt_match) ack_n = 1'b1;
        else if (rt_st == RT_IDLE || rt_st == RT_DONE) rt_latch = 1'b1;
      end else if (h_we) begin
        if (!wf_full) begin
          wf_push = 1'b1;
          ack_n   = 1'b1;
        end
      end else if (pf_hit) begin
        if (!rf_empty) begin
          rf_pop = 1'b1;
          ack_n  = 1'b1;
        end
      end else begin
        pf_miss = 1'b1;
      end
    end
    wr_accept = ack_n && h_we;
    rf_flush  = !rf_en || wr_accept || pf_miss;
  end

  assign wf_pop  = done && (cur_src == SRC_WR);
  assign pf_busy = loc_req && (cur_src == SRC_PF);
  assign pf_done = done && (cur_src == SRC_PF);
  assign pf_want = pf_valid && !rf_flush && (rf_count < FULLV);
  assign rf_push = pf_done && !pf_discard && !rf_flush;

  ptc_lport #(.AW(AW), .DW(DW), .RW(RW)) u_lport (
    .clk(clk), .rst(rst),
    .wf_valid(!wf_empty),
    .wf_addr(wf_dout[DW +: AW]), .wf_data(wf_dout[DW-1:0]),
    .wf_be(wf_dout[DW+AW +: BEW]), .wf_region(wf_dout[EW-1 -: RW]),
    .wf_burst(wf_dout[DW+AW+BEW]),
    .rt_pend(rt_st == RT_PEND), .rt_we(rt_we), .rt_addr(rt_addr),
    .rt_data(rt_wdata), .rt_be(rt_be), .rt_region(rt_region), .rt_burst(rt_burst),
    .pf_want(pf_want), .pf_addr(pf_faddr), .pf_region(pf_region),
    .loc_ack(loc_ack), .loc_req(loc_req), .loc_we(loc_we), .loc_addr(loc_addr),
    .loc_be(loc_be), .loc_region(loc_region), .loc_burst(loc_burst),
    .loc_wdata(loc_wdata), .issue_src(issue_src), .cur_src(cur_src), .done(done)
  );

  // prefetch stream tracking
  always_ff @(posedge clk) begin
    if (rst) begin
      pf_valid   <= 1'b0;
      pf_discard <= 1'b0;
      pf_region  <= '0;
      pf_haddr   <= '0;
      pf_faddr   <= '0;
    end else begin
      if (rf_flush) begin
        pf_valid  <= pf_miss;
        pf_region <= h_region;
        pf_haddr  <= h_addr;
        pf_faddr  <= h_addr;
      end else begin
        if (rf_pop)  pf_haddr <= pf_haddr + STEP;
        if (rf_push) pf_faddr <= pf_faddr + STEP;
      end
      // a fetch in flight across a flush returns stale data: drop it
      if (pf_done)                  pf_discard <= 1'b0;
      else if (rf_flush && pf_busy) pf_discard <= 1'b1;
    end
  end

  // real-time slot
  always_ff @(posedge clk) begin
    if (rst) begin
      rt_st     <= RT_IDLE;
      rt_we     <= 1'b0;
      rt_burst  <= 1'b0;
      rt_addr   <= '0;
      rt_wdata  <= '0;
      rt_rdata  <= '0;
      rt_be     <= '0;
      rt_region <= '0;
    end else if (rt_latch) begin
      rt_st     <= RT_PEND;
      rt_we     <= h_we;
      rt_burst  <= h_burst;
      rt_addr   <= h_addr;
      rt_wdata  <= h_wdata;
      rt_be     <= h_be;
      rt_region <= h_region;
    end else if (h_req && use_rt && rt_match) begin
      rt_st <= RT_IDLE;
    end else if (issue_src == SRC_RT) begin
      rt_st <= RT_BUSY;
    end else if (done && cur_src == SRC_RT) begin
      rt_st    <= RT_DONE;
      rt_rdata <= loc_rdata;
    end
  end

  // registered host response
  always_ff @(posedge clk) begin
    if (rst) begin
      h_ack   <= 1'b0;
      h_retry <= 1'b0;
      h_rdata <= '0;
    end else begin
      h_ack   <= ack_n;
      h_retry <= h_req && !ack_n;
      if (ack_n && !h_we) h_rdata <= use_rt ? rt_rdata : rf_dout;
    end
  end
endmodule

// File: rtl/ptc_chk.sv
module ptc_chk #(
  parameter int DEPTH = 8,
  parameter int AW    = 32
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   h_req,
  input logic                   h_we,
  input logic                   h_ack,
  input logic                   h_retry,
  input logic                   wf_en,
  input logic                   loc_req,
  input logic                   loc_ack,
  input logic                   loc_we,
  input logic [AW-1:0]          loc_addr,
  input logic [$clog2(DEPTH):0] wf_count,
  input logic [$clog2(DEPTH):0] rf_count
);
  localparam int CW = $clog2(DEPTH) + 1;
  localparam logic [CW-1:0] FULLV = CW'(DEPTH);

  a_r1_one_answer: assert property (@(posedge clk) disable iff (rst)
    $onehot0({h_ack, h_retry}));
  a_r1_beat_answered: assert property (@(posedge clk) disable iff (rst)
    h_req |=> (h_ack || h_retry));
  a_r1_no_stray_answer: assert property (@(posedge clk) disable iff (rst)
    !h_req |=> !(h_ack || h_retry));
  a_r2_room_acks: assert property (@(posedge clk) disable iff (rst)
    (h_req && h_we && wf_en && wf_count < FULLV) |=> h_ack);
  a_r3_full_retries: assert property (@(posedge clk) disable iff (rst)
    (h_req && h_we && wf_en && wf_count == FULLV) |=> h_retry);
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (wf_count <= FULLV) && (rf_count <= FULLV));
  a_r10_loc_hold: assert property (@(posedge clk) disable iff (rst)
    (loc_req && !loc_ack) |=> (loc_req && $stable(loc_addr) && $stable(loc_we)));
endmodule

bind ptc_top ptc_chk #(.DEPTH(DEPTH), .AW(AW)) u_ptc_chk (
  .clk(clk), .rst(rst), .h_req(h_req), .h_we(h_we), .h_ack(h_ack),
  .h_retry(h_retry), .wf_en(wf_en), .loc_req(loc_req), .loc_ack(loc_ack),
  .loc_we(loc_we), .loc_addr(loc_addr), .wf_count(wf_count), .rf_count(rf_count)
);

// File: tb/test_ptc_top.sv
module test_ptc_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        wf_en, rf_en;
  logic        h_req, h_we, h_burst;
  logic [31:0] h_addr, h_wdata;
  logic [3:0]  h_be;
  logic [1:0]  h_region;
  logic        h_ack, h_retry;
  logic [31:0] h_rdata;
  logic        loc_req, loc_we, loc_burst;
  logic [31:0] loc_addr, loc_wdata;
  logic [3:0]  loc_be;
  logic [1:0]  loc_region;
  logic        loc_ack;
  logic [31:0] loc_rdata;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  ptc_top i_ptc_top (
    .clk(clk), .rst(rst), .wf_en(wf_en), .rf_en(rf_en),
    .h_req(h_req), .h_we(h_we), .h_addr(h_addr), .h_be(h_be),
    .h_region(h_region), .h_burst(h_burst), .h_wdata(h_wdata),
    .h_ack(h_ack), .h_retry(h_retry), .h_rdata(h_rdata),
    .loc_req(loc_req), .loc_we(loc_we), .loc_addr(loc_addr), .loc_be(loc_be),
    .loc_region(loc_region), .loc_burst(loc_burst), .loc_wdata(loc_wdata),
    .loc_ack(loc_ack), .loc_rdata(loc_rdata)
  );

  // read data the local model returns: derived from address and region
  function automatic logic [31:0] fdat(input logic [31:0] a, input logic [1:0] r);
    return a ^ {r, 6'h15, 24'h0};
  endfunction

  // local-side model with adjustable latency and a stall switch
  int   lat = 2;
  logic stall = 1'b0;
  int   wcnt = 0;
  int   n_log = 0;
  int   n_rd = 0;
  logic        lg_we  [256];
  logic [31:0] lg_addr[256];
  logic [31:0] lg_data[256];
  logic [3:0]  lg_be  [256];
  logic [1:0]  lg_reg [256];
  logic        lg_bu  [256];

  always @(negedge clk) begin
    if (rst || loc_ack) begin
      loc_ack <= 1'b0;
      wcnt = 0;
    end else if (loc_req && !stall) begin
      if (wcnt >= lat) begin
        loc_ack   <= 1'b1;
        loc_rdata <= fdat(loc_addr, loc_region);
        if (n_log < 256) begin
          lg_we[n_log] = loc_we;   lg_addr[n_log] = loc_addr;
          lg_data[n_log] = loc_wdata; lg_be[n_log] = loc_be;
          lg_reg[n_log] = loc_region; lg_bu[n_log] = loc_burst;
          n_log++;
        end
        if (!loc_we) n_rd++;
      end else begin
        wcnt++;
      end
    end
  end

  task automatic chk(input logic ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic access(input logic we, input logic [31:0] a, input logic [3:0] be,
                        input logic [1:0] rg, input logic bu, input logic [31:0] wd,
                        output logic ack, output logic rty, output logic [31:0] rd);
    @(negedge clk);
    h_req = 1'b1; h_we = we; h_addr = a; h_be = be; h_region = rg; h_burst = bu; h_wdata = wd;
    @(negedge clk);
    h_req = 1'b0;
    ack = h_ack; rty = h_retry; rd = h_rdata;
  endtask

  task automatic access_until(input logic we, input logic [31:0] a, input logic [3:0] be,
                              input logic [1:0] rg, input logic bu, input logic [31:0] wd,
                              output logic [31:0] rd, output int tries);
    logic ack, rty;
    ack = 1'b0; tries = 0;
    while (!ack && tries < 300) begin
      access(we, a, be, rg, bu, wd, ack, rty, rd);
      tries++;
      if (!ack) repeat (2) @(negedge clk);
    end
  endtask

  logic        b_ack[16], b_rty[16];
  logic [31:0] b_dat[16];

  // back-to-back beats, one per cycle; answer i is sampled while beat i+1 is driven
  task automatic burst(input logic we, input logic [31:0] base, input int n, input logic [1:0] rg);
    for (int i = 0; i <= n; i++) begin
      @(negedge clk);
      if (i > 0) begin
        b_ack[i-1] = h_ack; b_rty[i-1] = h_retry; b_dat[i-1] = h_rdata;
      end
      if (i < n) begin
        h_req = 1'b1; h_we = we; h_addr = base + 32'(4*i); h_be = 4'hF;
        h_region = rg; h_burst = 1'b1; h_wdata = 32'hD000_0000 + 32'(i);
      end else begin
        h_req = 1'b0;
      end
    end
  endtask

  // posted-write vectors: {region[70:69], burst[68], addr[67:36], be[35:32], data[31:0]}
  localparam logic [70:0] VEC [6] = '{
    {2'd1, 1'b0, 32'h0000_0100, 4'hF, 32'h1234_5678},
    {2'd0, 1'b1, 32'h0000_0104, 4'h1, 32'hAAAA_00EE},
    {2'd3, 1'b0, 32'h0000_0A08, 4'h6, 32'h0BAD_F00D},
    {2'd2, 1'b1, 32'h0000_0A0C, 4'h8, 32'h8000_0001},
    {2'd1, 1'b0, 32'h0001_0000, 4'hC, 32'hFEED_BEEF},
    {2'd0, 1'b0, 32'h0000_0010, 4'h3, 32'h0000_55AA}
  };

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic        ack, rty;
    logic [31:0] rd;
    int          tries, n0, nr0;
    logic [31:0] A;

    rst = 1'b1; wf_en = 1'b1; rf_en = 1'b0;
    h_req = 1'b0; h_we = 1'b0; h_addr = '0; h_be = '0; h_region = '0; h_burst = 1'b0; h_wdata = '0;
    loc_ack = 1'b0; loc_rdata = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(!h_ack && !h_retry && !loc_req, "R1 outputs idle after reset",
        {29'd0, h_ack, h_retry, loc_req}, 32'd0);

    // table walk: posted writes, each checked on the local side (R2, R4)
    for (int i = 0; i < 6; i++) begin
      access(1'b1, VEC[i][67:36], VEC[i][35:32], VEC[i][70:69], VEC[i][68], VEC[i][31:0], ack, rty, rd);
      chk(ack && !rty, "R2 posted write acked at once", {30'd0, ack, rty}, 32'd2);
      repeat (20) @(negedge clk);
      chk(lg_we[n_log-1] && lg_addr[n_log-1] == VEC[i][67:36], "R4 local address", lg_addr[n_log-1], VEC[i][67:36]);
      chk(lg_data[n_log-1] == VEC[i][31:0], "R4 local data", lg_data[n_log-1], VEC[i][31:0]);
      chk({lg_reg[n_log-1], lg_bu[n_log-1], lg_be[n_log-1]} == {VEC[i][70:68], VEC[i][35:32]},
          "R4 local region/burst/lanes", {25'd0, lg_reg[n_log-1], lg_bu[n_log-1], lg_be[n_log-1]},
          {25'd0, VEC[i][70:68], VEC[i][35:32]});
    end

    // zero-wait burst into a stalled local side, ninth beat hits a full queue
    stall = 1'b1;
    n0 = n_log;
    burst(1'b1, 32'h0000_2000, 9, 2'd0);
    for (int i = 0; i < 8; i++)
      chk(b_ack[i] && !b_rty[i], "R2 burst beat acked", {30'd0, b_ack[i], b_rty[i]}, 32'd2);
    chk(!b_ack[8] && b_rty[8], "R3 write into full queue retried", {30'd0, b_ack[8], b_rty[8]}, 32'd1);
    repeat (5) @(negedge clk);
    chk(n_log == n0, "R3 nothing completed while stalled", 32'(n_log), 32'(n0));
    stall = 1'b0;
    access_until(1'b1, 32'h0000_2020, 4'hF, 2'd0, 1'b1, 32'hD000_0008, rd, tries);
    chk(tries < 300, "R3 retried write accepted after drain", 32'(tries), 32'd1);
    repeat (60) @(negedge clk);
    chk(n_log == n0 + 9, "R3 exactly nine writes reached local", 32'(n_log), 32'(n0 + 9));
    for (int i = 0; i < 9; i++)
      chk(lg_addr[n0+i] == 32'h2000 + 32'(4*i) && lg_data[n0+i] == 32'hD000_0000 + 32'(i),
          "R4 drain order", lg_addr[n0+i], 32'h2000 + 32'(4*i));

    // real-time write
    wf_en = 1'b0; lat = 5;
    n0 = n_log;
    access(1'b1, 32'h0000_3000, 4'h5, 2'd2, 1'b0, 32'hCAFE_0001, ack, rty, rd);
    chk(!ack && rty, "R5 real-time write first answer is retry", {30'd0, ack, rty}, 32'd1);
    access_until(1'b1, 32'h0000_3000, 4'h5, 2'd2, 1'b0, 32'hCAFE_0001, rd, tries);
    chk(tries < 300 && n_log == n0 + 1, "R5 real-time write completes once", 32'(n_log), 32'(n0 + 1));
    chk(lg_we[n0] && lg_addr[n0] == 32'h3000 && lg_data[n0] == 32'hCAFE_0001 && lg_be[n0] == 4'h5,
        "R5 local write content", lg_data[n0], 32'hCAFE_0001);

    // real-time read
    wf_en = 1'b1;
    access(1'b0, 32'h0000_4000, 4'hF, 2'd1, 1'b0, '0, ack, rty, rd);
    chk(!ack && rty, "R6 real-time read first answer is retry", {30'd0, ack, rty}, 32'd1);
    access_until(1'b0, 32'h0000_4000, 4'hF, 2'd1, 1'b0, '0, rd, tries);
    chk(rd == fdat(32'h4000, 2'd1), "R6 real-time read data", rd, fdat(32'h4000, 2'd1));

    // prefetch stream
    rf_en = 1'b1; lat = 1;
    @(negedge clk);
    A = 32'h0000_5000;
    nr0 = n_rd;
    access(1'b0, A, 4'hF, 2'd2, 1'b1, '0, ack, rty, rd);
    chk(!ack && rty, "R7 new stream retried", {30'd0, ack, rty}, 32'd1);
    repeat (60) @(negedge clk);
    chk(n_rd - nr0 == 8, "R7 prefetch stops at eight words", 32'(n_rd - nr0), 32'd8);
    chk(!lg_we[n_log-1] && lg_be[n_log-1] == 4'hF && lg_bu[n_log-1] && lg_reg[n_log-1] == 2'd2,
        "R10 prefetch request fields", {25'd0, lg_we[n_log-1], lg_reg[n_log-1], lg_bu[n_log-1], lg_be[n_log-1]},
        {25'd0, 1'b0, 2'd2, 1'b1, 4'hF});
    chk(lg_addr[n_log-1] == A + 32'd28, "R7 prefetch addresses consecutive", lg_addr[n_log-1], A + 32'd28);
    lat = 0;
    burst(1'b0, A, 8, 2'd2);
    for (int i = 0; i < 8; i++)
      chk(b_ack[i] && b_dat[i] == fdat(A + 32'(4*i), 2'd2), "R7 zero-wait read beat",
          b_dat[i], fdat(A + 32'(4*i), 2'd2));
    access_until(1'b0, A + 32'd32, 4'hF, 2'd2, 1'b1, '0, rd, tries);
    chk(rd == fdat(A + 32'd32, 2'd2), "R7 stream continues after burst", rd, fdat(A + 32'd32, 2'd2));

    // region change and non-sequential address flush
    repeat (20) @(negedge clk);
    access(1'b0, A + 32'd36, 4'hF, 2'd3, 1'b1, '0, ack, rty, rd);
    chk(!ack && rty, "R8 region change retried", {30'd0, ack, rty}, 32'd1);
    access_until(1'b0, A + 32'd36, 4'hF, 2'd3, 1'b1, '0, rd, tries);
    chk(rd == fdat(A + 32'd36, 2'd3), "R8 data from new region", rd, fdat(A + 32'd36, 2'd3));
    repeat (20) @(negedge clk);
    access(1'b0, A + 32'd100, 4'hF, 2'd3, 1'b1, '0, ack, rty, rd);
    chk(!ack && rty, "R8 non-sequential read retried", {30'd0, ack, rty}, 32'd1);
    access_until(1'b0, A + 32'd100, 4'hF, 2'd3, 1'b1, '0, rd, tries);
    chk(rd == fdat(A + 32'd100, 2'd3), "R8 data from new address", rd, fdat(A + 32'd100, 2'd3));

    // write flushes the prefetched stream
    repeat (30) @(negedge clk);
    access(1'b1, 32'h0000_6000, 4'hF, 2'd0, 1'b0, 32'h0000_0077, ack, rty, rd);
    chk(ack, "R9 posted write accepted", {31'd0, ack}, 32'd1);
    access(1'b0, A + 32'd104, 4'hF, 2'd3, 1'b1, '0, ack, rty, rd);
    chk(!ack && rty, "R9 read after write retried", {30'd0, ack, rty}, 32'd1);
    access_until(1'b0, A + 32'd104, 4'hF, 2'd3, 1'b1, '0, rd, tries);
    chk(rd == fdat(A + 32'd104, 2'd3), "R9 refetched data", rd, fdat(A + 32'd104, 2'd3));

    repeat (5) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule